// File: doc/BRIEF.md
# NAND Identification and Status Responder

This block answers the two query commands of a NAND flash front end: the identification query and the status query. A command sequencer decodes the command bytes and hands this block one-cycle trigger pulses. After an identification trigger, each read strobe returns the next byte of a four-byte identification sequence. After a status trigger, each read strobe returns the status register, and the status does not advance between reads.

The status register holds sticky flags that the array controller sets: an error flag, four plane flags and a busy flag. Its top bit follows the active-low write-protect input, so it reads 1 when the device is writable. The manufacturer code, the device code and two geometry flags are static configuration inputs. The geometry flags are the large-page flag and the 16-bit bus flag. The responder only drives the low byte of the data-out word. Page data is handled elsewhere.

Top module: `nand_idstat_resp`

## Requirements
- R1: After synchronous reset, `dout_o` is 0, the responder is idle (a read strobe returns 0), and status bits 6..0 are 0.
- R2: `stat_set_i` sets status flags that stay set until cleared. Bit 0 is error, bits 4..1 are plane flags 3..0 and bit 6 is busy. Bit 5 always reads 0, and bits 5 and 7 of `stat_set_i` are ignored.
- R3: Status bit 7 equals the level of `wp_n_i` sampled on the previous clock edge.
- R4: After `cmd_id_i`, successive accepted reads return, in this order: `mfr_id_i`, `dev_id_i`, the constant 0xA5, and the geometry byte.
- R5: The geometry byte depends on the two flags. It is 0x15 when `large_page_i`=1 and `bus16_i`=0. It is 0x55 when `large_page_i`=1 and `bus16_i`=1. It is 0xC0 when `large_page_i`=0.
- R6: After `cmd_status_i`, every accepted read returns the current status byte and nothing advances. This lasts until `cmd_id_i`, `cmd_other_i` or `cmd_reset_i` arrives. After `cmd_other_i`, reads return 0.
- R7: `cmd_reset_i` clears status bits 6..0, keeps bit 7 and returns the responder to idle.
- R8: A read strobe while `ce_n_i`=1 returns 0 and does not advance the identification position.
- R9: Once all four identification bytes have been read, further reads return 0. Reads in the idle state also return 0.
- R10: `dout_o` is registered. It changes in the cycle after a read strobe and holds its value between strobes. The returned byte sits in bits 7..0, and all higher bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_id_i | input | 1 | Identification query trigger |
| cmd_status_i | input | 1 | Status query trigger |
| cmd_other_i | input | 1 | Any other command latched; ends a query |
| cmd_reset_i | input | 1 | Reset command strobe |
| rd_stb_i | input | 1 | Read strobe, one per data word |
| ce_n_i | input | 1 | Chip enable, active low |
| wp_n_i | input | 1 | Write protect, active low |
| stat_set_i | input | 8 | Status flag set mask from the array controller |
| mfr_id_i | input | 8 | Manufacturer code |
| dev_id_i | input | 8 | Device code |
| large_page_i | input | 1 | Large-page geometry flag |
| bus16_i | input | 1 | 16-bit bus flag |
| dout_o | output | BUS_W | Data-out word |

## Verification
The assertions assume that a read strobe never falls in the same cycle as a trigger or a status-set pulse. They also assume that the identification inputs and geometry flags stay stable during a query. The design still resolves such overlaps: a trigger wins and the coinciding read returns 0. The stimulus respects these assumptions by issuing one action per driver call, each on its own cycle. It changes `wp_n_i`, the flags and the configuration only between queries, and then waits a cycle before the next read.

// File: rtl/nidr_pkg.sv
package nidr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_ID   = 2'd1,
    MODE_STAT = 2'd2
  } nidr_mode_e;

  localparam int unsigned BYTE_W = 8;

  // status byte layout
  localparam int unsigned ST_ERR   = 0;
  localparam int unsigned ST_BUSY  = 6;
  localparam int unsigned ST_WPN   = 7;
  localparam logic [7:0]  ST_STICKY_MASK = 8'h5F;

  // identification constants
  localparam logic [7:0] ID_FILLER    = 8'hA5;
  localparam logic [7:0] GEO_LP_X8    = 8'h15;
  localparam logic [7:0] GEO_LP_X16   = 8'h55;
  localparam logic [7:0] GEO_SMALL_PG = 8'hC0;

endpackage

// File: rtl/nidr_status_reg.sv
module nidr_status_reg
  import nidr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wp_n_i,
  input  logic       clr_i,
  input  logic [7:0] set_i,
  output logic [7:0] stat_o
);

  logic       wpn_q;
  logic [6:0] flags_q;

  // write-protect level is resampled every cycle, reset or not
  always_ff @(posedge clk) begin
    wpn_q <= wp_n_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_q | (set_i[6:0] & ST_STICKY_MASK[6:0]);
    end
  end

  assign stat_o = {wpn_q, flags_q};

  // R7
  clr_flags_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (stat_o[6:0] == 7'd0));

  // R3
  wp_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_o[ST_WPN] == $past(wp_n_i)));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stat_o[5] == 1'b0));

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_o[ST_ERR] && !clr_i) |=> stat_o[ST_ERR]);

  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i[ST_BUSY] && !clr_i) |=> stat_o[ST_BUSY]);

endmodule

// File: rtl/nidr_id_rom.sv
module nidr_id_rom
  import nidr_pkg::*;
#(
  parameter int unsigned ID_LEN = 4,
  localparam int unsigned PTR_W = $clog2(ID_LEN + 1)
) (
  input  logic [7:0]       mfr_id_i,
  input  logic [7:0]       dev_id_i,
  input  logic             large_page_i,
  input  logic             bus16_i,
  input  logic [PTR_W-1:0] sel_i,
  output logic [7:0]       byte_o
);

  logic [7:0] geo_byte;
  logic [7:0] tbl [ID_LEN];

  always_comb begin
    if (!large_page_i)  geo_byte = GEO_SMALL_PG;
    else if (bus16_i)   geo_byte = GEO_LP_X16;
    else                geo_byte = GEO_LP_X8;
  end

  for (genvar gi = 0; gi < ID_LEN; gi++) begin : g_tbl
    if (gi == 0) begin : g_mfr
      assign tbl[gi] = mfr_id_i;
    end else if (gi == 1) begin : g_dev
      assign tbl[gi] = dev_id_i;
    end else if (gi == 2) begin : g_fill
      assign tbl[gi] = ID_FILLER;
    end else if (gi == 3) begin : g_geo
      assign tbl[gi] = geo_byte;
    end else begin : g_pad
      assign tbl[gi] = 8'h00;
    end
  end

  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < ID_LEN; i++) begin
      if (sel_i == PTR_W'(i)) byte_o = tbl[i];
    end
  end

endmodule

// File: rtl/nidr_seq.sv
module nidr_seq
  import nidr_pkg::*;
#(
  parameter int unsigned ID_LEN = 4,
  localparam int unsigned PTR_W = $clog2(ID_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_id_i,
  input  logic             cmd_status_i,
  input  logic             cmd_other_i,
  input  logic             cmd_reset_i,
  input  logic             rd_stb_i,
  input  logic             ce_n_i,
  output nidr_mode_e       mode_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             emit_id_o,
  output logic             emit_stat_o
);

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(ID_LEN);

  nidr_mode_e       mode_q;
  logic [PTR_W-1:0] ptr_q;
  logic             cmd_any;
  logic             rd_ok;

  assign cmd_any     = cmd_id_i | cmd_status_i | cmd_other_i | cmd_reset_i;
  assign rd_ok       = rd_stb_i && !ce_n_i && !cmd_any;
  assign emit_id_o   = rd_ok && (mode_q == MODE_ID) && (ptr_q < PTR_END);
  assign emit_stat_o = rd_ok && (mode_q == MODE_STAT);

  always_ff @(posedge clk) begin
    if (rst || cmd_reset_i) begin
      mode_q <= MODE_IDLE;
      ptr_q  <= '0;
    end else if (cmd_id_i) begin
      mode_q <= MODE_ID;
      ptr_q  <= '0;
    end else if (cmd_status_i) begin
      mode_q <= MODE_STAT;
    end else if (cmd_other_i) begin
      mode_q <= MODE_IDLE;
    end else if (emit_id_o) begin
      ptr_q <= ptr_q + 1'b1;
    end
  end

  assign mode_o = mode_q;
  assign ptr_o  = ptr_q;

  // R9
  ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PTR_END);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_ID && rd_stb_i && !ce_n_i && !cmd_any && ptr_q < PTR_END)
      |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R8
  ce_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_n_i && !cmd_any) |=> (ptr_q == $past(ptr_q)));

  // R6
  stat_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STAT && !cmd_any) |=> (mode_q == MODE_STAT));

endmodule

// File: rtl/nand_idstat_resp.sv
module nand_idstat_resp
  import nidr_pkg::*;
#(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned ID_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_id_i,
  input  logic             cmd_status_i,
  input  logic             cmd_other_i,
  input  logic             cmd_reset_i,
  input  logic             rd_stb_i,
  input  logic             ce_n_i,
  input  logic             wp_n_i,
  input  logic [7:0]       stat_set_i,
  input  logic [7:0]       mfr_id_i,
  input  logic [7:0]       dev_id_i,
  input  logic             large_page_i,
  input  logic             bus16_i,
  output logic [BUS_W-1:0] dout_o
);

  localparam int unsigned PTR_W = $clog2(ID_LEN + 1);
  localparam int unsigned PAD_W = BUS_W - BYTE_W;

  nidr_mode_e       mode;
  logic [PTR_W-1:0] ptr;
  logic             emit_id;
  logic             emit_stat;
  logic [7:0]       stat;
  logic [7:0]       id_byte;
  logic [7:0]       rd_byte;
  logic [BUS_W-1:0] dout_q;

  nidr_status_reg u_status (
    .clk    (clk),
    .rst    (rst),
    .wp_n_i (wp_n_i),
    .clr_i  (cmd_reset_i),
    .set_i  (stat_set_i),
    .stat_o (stat)
  );

  nidr_seq #(.ID_LEN(ID_LEN)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .cmd_id_i     (cmd_id_i),
    .cmd_status_i (cmd_status_i),
    .cmd_other_i  (cmd_other_i),
    .cmd_reset_i  (cmd_reset_i),
    .rd_stb_i     (rd_stb_i),
    .ce_n_i       (ce_n_i),
    .mode_o       (mode),
    .ptr_o        (ptr),
    .emit_id_o    (emit_id),
    .emit_stat_o  (emit_stat)
  );

  nidr_id_rom #(.ID_LEN(ID_LEN)) u_rom (
    .mfr_id_i     (mfr_id_i),
    .dev_id_i     (dev_id_i),
    .large_page_i (large_page_i),
    .bus16_i      (bus16_i),
    .sel_i        (ptr),
    .byte_o       (id_byte)
  );

  always_comb begin
    if (emit_id)        rd_byte = id_byte;
    else if (emit_stat) rd_byte = stat;
    else                rd_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
    end else if (rd_stb_i) begin
      dout_q <= {{PAD_W{1'b0}}, rd_byte};
    end
  end

  assign dout_o = dout_q;

  // R8
  ce_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && ce_n_i) |=> (dout_o == '0));

  // R10
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dout_o[BUS_W-1:BYTE_W] == '0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb_i |=> $stable(dout_o));

  // R9
  exhaust_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_ID && ptr == PTR_W'(ID_LEN) && rd_stb_i) |=> (dout_o == '0));

  // R6
  stat_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_STAT && rd_stb_i && !ce_n_i && !cmd_id_i && !cmd_status_i
     && !cmd_other_i && !cmd_reset_i)
      |=> (dout_o[7:0] == $past(stat)));

endmodule

// File: tb/test_nand_idstat_resp.sv
module test_nand_idstat_resp;

  localparam int CLK_PERIOD = 10;
  localparam int BUS_W      = 16;

  typedef struct {
    logic [BUS_W-1:0] exp;
    string            tag;
  } sb_item_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_id = 1'b0, cmd_status = 1'b0, cmd_other = 1'b0, cmd_reset = 1'b0;
  logic             rd_stb = 1'b0;
  logic             ce_n = 1'b0;
  logic             wp_n = 1'b1;
  logic [7:0]       stat_set = 8'h00;
  logic [7:0]       mfr_id = 8'hEC;
  logic [7:0]       dev_id = 8'hDA;
  logic             large_page = 1'b1;
  logic             bus16 = 1'b0;
  logic [BUS_W-1:0] dout;

  int       n_chk  = 0;
  int       n_fail = 0;
  logic     pend   = 1'b0;
  sb_item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_idstat_resp #(.BUS_W(BUS_W)) i_nand_idstat_resp (
    .clk          (clk),
    .rst          (rst),
    .cmd_id_i     (cmd_id),
    .cmd_status_i (cmd_status),
    .cmd_other_i  (cmd_other),
    .cmd_reset_i  (cmd_reset),
    .rd_stb_i     (rd_stb),
    .ce_n_i       (ce_n),
    .wp_n_i       (wp_n),
    .stat_set_i   (stat_set),
    .mfr_id_i     (mfr_id),
    .dev_id_i     (dev_id),
    .large_page_i (large_page),
    .bus16_i      (bus16),
    .dout_o       (dout)
  );

  task automatic check(input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp,
                       input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // monitor: a strobe registered at a posedge is compared at the next negedge
  always @(posedge clk) pend <= rd_stb;

  always @(negedge clk) begin
    if (pend) begin
      if (sbq.size() == 0) begin
        check(dout, 'x, "scoreboard underflow");
      end else begin
        sb_item_t it;
        it = sbq.pop_front();
        check(dout, it.exp, it.tag);
      end
    end
  end

  task automatic rd(input logic [7:0] exp_byte, input string tag);
    sb_item_t it;
    @(negedge clk);
    it.exp = {8'h00, exp_byte};
    it.tag = tag;
    sbq.push_back(it);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: cmd_id = 1'b1;
      1: cmd_status = 1'b1;
      2: cmd_other = 1'b1;
      default: cmd_reset = 1'b1;
    endcase
    @(negedge clk);
    cmd_id = 1'b0; cmd_status = 1'b0; cmd_other = 1'b0; cmd_reset = 1'b0;
  endtask

  task automatic set_flags(input logic [7:0] m);
    @(negedge clk);
    stat_set = m;
    @(negedge clk);
    stat_set = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    // R1 reset state
    check(dout, '0, "R1 dout during reset");
    @(negedge clk); rst = 1'b0;
    idle(1);
    check(dout, '0, "R1 dout after reset");
    rd(8'h00, "R1 idle read returns 0");
    rd(8'h00, "R9 idle read returns 0");

    // R4 / R5 large page, 8-bit
    pulse(0);
    rd(8'hEC, "R4 byte0 manufacturer");
    rd(8'hDA, "R4 byte1 device");
    rd(8'hA5, "R4 byte2 filler");
    rd(8'h15, "R5 geometry large x8");
    rd(8'h00, "R9 read past end");
    rd(8'h00, "R9 second read past end");

    // R5 large page, 16-bit; R10 upper byte zero
    @(negedge clk); bus16 = 1'b1; mfr_id = 8'h2C; dev_id = 8'hBA;
    pulse(0);
    rd(8'h2C, "R10 manufacturer in low byte x16");
    rd(8'hBA, "R4 device x16");
    rd(8'hA5, "R4 filler x16");
    rd(8'h55, "R5 geometry large x16");

    // R5 small page
    @(negedge clk); large_page = 1'b0; bus16 = 1'b0;
    pulse(0);
    rd(8'h2C, "R4 manufacturer small");
    rd(8'hBA, "R4 device small");
    rd(8'hA5, "R4 filler small");
    rd(8'hC0, "R5 geometry small page");

    // R8 CE# high: zero, no advance
    pulse(0);
    rd(8'h2C, "R8 first byte before ce high");
    @(negedge clk); ce_n = 1'b1;
    rd(8'h00, "R8 ce high read");
    @(negedge clk); ce_n = 1'b0;
    rd(8'hBA, "R8 position kept across ce high");

    // R6 / R3 status mode
    pulse(1);
    rd(8'h80, "R3 status writable");
    rd(8'h80, "R6 status repeat");
    set_flags(8'hFF);
    rd(8'hDF, "R2 flags set bit5 ignored");
    rd(8'hDF, "R6 status repeat after flags");
    @(negedge clk); wp_n = 1'b0;
    rd(8'h5F, "R3 wp low clears bit7");
    @(negedge clk); wp_n = 1'b1;
    rd(8'hDF, "R3 wp high sets bit7");

    // R6 another command ends status mode
    pulse(2);
    rd(8'h00, "R6 other command ends status");

    // R6 id command ends status mode
    pulse(1);
    rd(8'hDF, "R6 back in status");
    pulse(0);
    rd(8'h2C, "R6 id after status");

    // R7 reset command
    pulse(3);
    rd(8'h00, "R7 reset returns to idle");
    pulse(1);
    rd(8'h80, "R7 reset cleared flags kept wp");
    set_flags(8'h02);
    rd(8'h82, "R2 plane0 flag bit1");

    // R10 hold between strobes
    idle(3);
    check(dout, 16'h0082, "R10 dout held between strobes");

    // R1 synchronous reset mid-run
    set_flags(8'h41);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(dout, '0, "R1 dout after mid reset");
    rd(8'h00, "R1 idle after mid reset");
    pulse(1);
    rd(8'h80, "R1 flags cleared by reset");

    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule